// File: doc/BRIEF.md
# Multi-Slot Wavefront Barrier

This unit lets a group of wavefronts, possibly spread over many compute units, wait for one another. It holds a small number of independent barrier slots. One requester arms a slot by writing the number of participants minus one, together with an optional watchdog limit. Wavefronts then arrive at the slot, naming it by its ID and identifying themselves by a wave tag. Each arriving wavefront is held. When the last expected participant arrives, every held wavefront of that slot is released in the same cycle, and the slot drops back to unarmed.

A slot is single-use: each barrier episode needs a fresh arm. Software is expected to rotate across two or three slots, arming the next slot before arriving at the current one. Misuse has defined results. A wavefront that arrives at an unarmed slot stays held with no time limit, which is how the deadlock from a late arming wavefront shows up. An arm request that collides with a slot still in use is refused and leaves a sticky error bit. A watchdog, when enabled, frees the held wavefronts with a timeout flag.

One arrival request can carry several wave tags at once, all for the same slot. The release output pulses for one cycle with the slot ID and a mask of the released tags.

Top module: `wave_barrier`

## Requirements
- R1: After reset every slot is unarmed and holds no wavefront. relValid is 0, relMask is 0 and errFlag is 0.
- R2: initCount holds the number of participants minus one, so initCount=1 arms a slot for two wavefronts. The release pulse appears in the cycle after the edge that samples the arrival completing the count.
- R3: A release drives relValid high for exactly one cycle, together with the slot in relSlot and every held tag of that slot in relMask (bit i is wave tag i). While relValid is low, relMask is 0 and relTimeout is 0.
- R4: Slots are independent. An arrival at one slot never changes the count, the held set or the release of another slot.
- R5: After a release the slot is unarmed. Later arrivals to it are held and never released until it is armed again, and no slot releases in two consecutive cycles.
- R6: An arrival at an unarmed slot is held indefinitely and produces no release.
- R7: An arm request is refused, and errFlag bit s (for slot s) is set, when slot s already holds a wavefront, receives a non-empty arrival in the same cycle, or releases in that same cycle. errFlag bits stay set until reset. Re-arming an armed slot that holds no wavefront is accepted.
- R8: All tags in one arrival mask are counted together. A tag that is already held at that slot is not counted a second time.
- R9: With a non-zero initLimit L, an armed slot that has not completed releases its held tags (possibly none) with relTimeout=1 in the cycle after the L-th edge following its arming edge. L=0 disables the watchdog.
- R10: Only one slot releases per cycle. A completing arrival takes priority over watchdog expiry. Among expired slots the lowest slot number goes first, and the others wait with their expiry pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initValid | input | 1 | Arm request strobe |
| initSlot | input | SLOT_W | Slot to arm |
| initCount | input | CNT_W | Participants minus one |
| initLimit | input | TIMER_W | Watchdog limit in cycles, 0 = off |
| arriveValid | input | 1 | Arrival request strobe |
| arriveSlot | input | SLOT_W | Slot the arrivals target |
| arriveMask | input | NUM_WAVES | One bit per arriving wave tag |
| relValid | output | 1 | Release pulse |
| relSlot | output | SLOT_W | Slot being released |
| relMask | output | NUM_WAVES | Released wave tags |
| relTimeout | output | 1 | Release caused by the watchdog |
| errFlag | output | NUM_SLOTS | Sticky refused-arm flags, one per slot |

## Verification
The hardest situation to reach is the one where several release causes meet in a single cycle: two watchdogs expiring on the same edge while a different slot completes through an arrival. The stimulus gets there by arming two slots one cycle apart, with limits chosen so that both timers run out on the same edge, and by timing a completing arrival for a third slot onto that edge. The release order can then be seen over three cycles. Arm requests that collide with held wavefronts, with a same-cycle arrival, or with a release are driven on purpose. A behavioural model checks the error flags and the release pulses on every clock.

// File: rtl/wbar_pkg.sv
package wbar_pkg;

  // Strobes from the slot controller to the hold datapath.
  typedef struct packed {
    logic arrive;   // fold arriving tags into the addressed slot
    logic fire;     // release the selected slot this cycle
    logic timeout;  // the release is caused by watchdog expiry
  } wbarCmd_t;

endpackage

// File: rtl/wbar_datapath.sv
module wbar_datapath
  import wbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_WAVES = 64,
  parameter int SLOT_W    = 2,
  parameter int NCNT_W    = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SLOT_W-1:0]    arriveSlot,
  input  logic [NUM_WAVES-1:0] arriveMask,
  input  wbarCmd_t             cmd,
  input  logic [SLOT_W-1:0]    relSel,
  output logic [NUM_SLOTS-1:0] heldAny,
  output logic [NCNT_W-1:0]    newCount,
  output logic                 relValid,
  output logic [SLOT_W-1:0]    relSlot,
  output logic [NUM_WAVES-1:0] relMask,
  output logic                 relTimeout
);

  logic [NUM_SLOTS-1:0][NUM_WAVES-1:0] held;
  logic [NUM_WAVES-1:0] newBits;
  logic [NUM_WAVES-1:0] fireMask;

  // Tags that are not already parked at the addressed slot.
  always_comb begin
    newBits = cmd.arrive ? (arriveMask & ~held[arriveSlot]) : '0;
    newCount = '0;
    for (int w = 0; w < NUM_WAVES; w++) begin
      newCount = newCount + NCNT_W'(newBits[w]);
    end
  end

  // Everything that leaves at a release, arrivals of this cycle included.
  always_comb begin
    fireMask = held[relSel];
    if (cmd.arrive && (arriveSlot == relSel)) begin
      fireMask = fireMask | newBits;
    end
  end

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_any
      assign heldAny[gs] = |held[gs];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cmd.fire && (relSel == SLOT_W'(s))) begin
          held[s] <= '0;
        end else if (cmd.arrive && (arriveSlot == SLOT_W'(s))) begin
          held[s] <= held[s] | newBits;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relValid   <= 1'b0;
      relSlot    <= '0;
      relMask    <= '0;
      relTimeout <= 1'b0;
    end else begin
      relValid   <= cmd.fire;
      relSlot    <= cmd.fire ? relSel : '0;
      relMask    <= cmd.fire ? fireMask : '0;
      relTimeout <= cmd.fire & cmd.timeout;
    end
  end

endmodule

// File: rtl/wbar_control.sv
module wbar_control
  import wbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8,
  parameter int TIMER_W   = 16,
  parameter int SLOT_W    = 2,
  parameter int NCNT_W    = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initValid,
  input  logic [SLOT_W-1:0]    initSlot,
  input  logic [CNT_W-1:0]     initCount,
  input  logic [TIMER_W-1:0]   initLimit,
  input  logic                 arriveValid,
  input  logic                 arriveAny,
  input  logic [SLOT_W-1:0]    arriveSlot,
  input  logic [NCNT_W-1:0]    newCount,
  input  logic [NUM_SLOTS-1:0] heldAny,
  output wbarCmd_t             cmd,
  output logic [SLOT_W-1:0]    relSel,
  output logic [NUM_SLOTS-1:0] errFlag
);

  localparam int REM_W = CNT_W + 1;
  localparam int CMP_W = (REM_W > NCNT_W) ? REM_W : NCNT_W;

  logic [NUM_SLOTS-1:0]              armed;
  logic [NUM_SLOTS-1:0][REM_W-1:0]   remaining;
  logic [NUM_SLOTS-1:0][TIMER_W-1:0] timer;

  logic [NUM_SLOTS-1:0] expiring;
  logic [NUM_SLOTS-1:0] arriveHit;
  logic                 complete;
  logic                 initOk;

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
      assign expiring[gs]  = armed[gs] && (timer[gs] == TIMER_W'(1));
      assign arriveHit[gs] = arriveValid && arriveAny && (arriveSlot == SLOT_W'(gs));
    end
  endgenerate

  // The arrival completes its slot when it covers what is still missing.
  assign complete = arriveValid && armed[arriveSlot] &&
                    (CMP_W'(newCount) >= CMP_W'(remaining[arriveSlot]));

  // Release selection: completion first, then the lowest expired slot.
  always_comb begin
    cmd.arrive  = arriveValid;
    cmd.fire    = 1'b0;
    cmd.timeout = 1'b0;
    relSel      = '0;
    if (complete) begin
      cmd.fire = 1'b1;
      relSel   = arriveSlot;
    end else begin
      for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
        if (expiring[s]) begin
          cmd.fire    = 1'b1;
          cmd.timeout = 1'b1;
          relSel      = SLOT_W'(s);
        end
      end
    end
  end

  // An arm is refused while the slot is busy in any way this cycle.
  assign initOk = initValid && !heldAny[initSlot] && !arriveHit[initSlot] &&
                  !(cmd.fire && (relSel == initSlot));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= '0;
      remaining <= '0;
      timer     <= '0;
      errFlag   <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cmd.fire && (relSel == SLOT_W'(s))) begin
          armed[s]     <= 1'b0;
          remaining[s] <= '0;
          timer[s]     <= '0;
        end else if (initOk && (initSlot == SLOT_W'(s))) begin
          armed[s]     <= 1'b1;
          remaining[s] <= REM_W'(initCount) + REM_W'(1);
          timer[s]     <= initLimit;
        end else if (armed[s]) begin
          if (arriveHit[s]) begin
            remaining[s] <= remaining[s] - REM_W'(newCount);
          end
          if (timer[s] > TIMER_W'(1)) begin
            timer[s] <= timer[s] - TIMER_W'(1);
          end
        end
        if (initValid && !initOk && (initSlot == SLOT_W'(s))) begin
          errFlag[s] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wave_barrier.sv
module wave_barrier
  import wbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_WAVES = 64,
  parameter int CNT_W     = 8,
  parameter int TIMER_W   = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initValid,
  input  logic [SLOT_W-1:0]    initSlot,
  input  logic [CNT_W-1:0]     initCount,
  input  logic [TIMER_W-1:0]   initLimit,
  input  logic                 arriveValid,
  input  logic [SLOT_W-1:0]    arriveSlot,
  input  logic [NUM_WAVES-1:0] arriveMask,
  output logic                 relValid,
  output logic [SLOT_W-1:0]    relSlot,
  output logic [NUM_WAVES-1:0] relMask,
  output logic                 relTimeout,
  output logic [NUM_SLOTS-1:0] errFlag
);

  localparam int NCNT_W = $clog2(NUM_WAVES + 1);

  wbarCmd_t             cmd;
  logic [SLOT_W-1:0]    relSel;
  logic [NUM_SLOTS-1:0] heldAny;
  logic [NCNT_W-1:0]    newCount;
  logic                 arriveAny;

  assign arriveAny = |arriveMask;

  wbar_control #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .TIMER_W(TIMER_W),
    .SLOT_W(SLOT_W), .NCNT_W(NCNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .initValid(initValid), .initSlot(initSlot), .initCount(initCount),
    .initLimit(initLimit), .arriveValid(arriveValid), .arriveAny(arriveAny),
    .arriveSlot(arriveSlot), .newCount(newCount), .heldAny(heldAny),
    .cmd(cmd), .relSel(relSel), .errFlag(errFlag)
  );

  wbar_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_WAVES(NUM_WAVES),
    .SLOT_W(SLOT_W), .NCNT_W(NCNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .arriveSlot(arriveSlot), .arriveMask(arriveMask),
    .cmd(cmd), .relSel(relSel), .heldAny(heldAny), .newCount(newCount),
    .relValid(relValid), .relSlot(relSlot), .relMask(relMask),
    .relTimeout(relTimeout)
  );

endmodule

// File: rtl/wave_barrier_checker.sv
module wave_barrier_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_WAVES = 64,
  parameter int SLOT_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 initValid,
  input logic [SLOT_W-1:0]    initSlot,
  input logic                 arriveValid,
  input logic [SLOT_W-1:0]    arriveSlot,
  input logic [NUM_WAVES-1:0] arriveMask,
  input logic                 relValid,
  input logic [SLOT_W-1:0]    relSlot,
  input logic [NUM_WAVES-1:0] relMask,
  input logic                 relTimeout,
  input logic [NUM_SLOTS-1:0] errFlag
);

  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !relValid |-> (relMask == '0) && !relTimeout);

  a_r3_completion_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !relTimeout) |-> (relMask != '0));

  a_r5_no_repeat_release: assert property (@(posedge clk) disable iff (!rstN)
    relValid |=> !(relValid && (relSlot == $past(relSlot))));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (($past(errFlag) & ~errFlag) == '0));

  a_r7_collision_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (initValid && arriveValid && (arriveMask != '0) && (initSlot == arriveSlot))
      |=> errFlag[$past(initSlot)]);

endmodule

bind wave_barrier wave_barrier_checker #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_WAVES(NUM_WAVES), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .initValid(initValid), .initSlot(initSlot),
  .arriveValid(arriveValid), .arriveSlot(arriveSlot), .arriveMask(arriveMask),
  .relValid(relValid), .relSlot(relSlot), .relMask(relMask),
  .relTimeout(relTimeout), .errFlag(errFlag)
);

// File: tb/wave_barrier_tb_top.sv
module wave_barrier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initValid = 1'b0;
  logic [1:0]  initSlot = '0;
  logic [7:0]  initCount = '0;
  logic [15:0] initLimit = '0;
  logic        arriveValid = 1'b0;
  logic [1:0]  arriveSlot = '0;
  logic [63:0] arriveMask = '0;
  logic        relValid;
  logic [1:0]  relSlot;
  logic [63:0] relMask;
  logic        relTimeout;
  logic [3:0]  errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // Reference model state
  bit          mArmed [NS];
  int          mRem   [NS];
  int          mTimer [NS];
  logic [63:0] mHeld  [NS];
  logic [3:0]  mErr;
  bit          mRelV;
  int          mRelS;
  logic [63:0] mRelM;
  bit          mRelT;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wave_barrier dut_i (
    .clk(clk), .rstN(rstN),
    .initValid(initValid), .initSlot(initSlot), .initCount(initCount),
    .initLimit(initLimit), .arriveValid(arriveValid), .arriveSlot(arriveSlot),
    .arriveMask(arriveMask), .relValid(relValid), .relSlot(relSlot),
    .relMask(relMask), .relTimeout(relTimeout), .errFlag(errFlag)
  );

  task automatic modelReset();
    for (int s = 0; s < NS; s++) begin
      mArmed[s] = 0; mRem[s] = 0; mTimer[s] = 0; mHeld[s] = '0;
    end
    mErr = '0; mRelV = 0; mRelS = 0; mRelM = '0; mRelT = 0;
  endtask

  task automatic modelStep();
    logic [63:0] nb;
    int cnt;
    bit fire;
    bit to;
    int fs;
    bit hit;
    bit bad;
    int as;
    int is;
    as = int'(arriveSlot);
    is = int'(initSlot);
    nb = arriveValid ? (arriveMask & ~mHeld[as]) : '0;
    cnt = $countones(nb);
    hit = arriveValid && (arriveMask != '0);
    fire = 0; to = 0; fs = 0;
    if (arriveValid && mArmed[as] && cnt >= mRem[as]) begin
      fire = 1; fs = as;
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (!fire && mArmed[s] && mTimer[s] == 1) begin
          fire = 1; to = 1; fs = s;
        end
      end
    end
    bad = initValid && ((mHeld[is] != '0) || (hit && as == is) || (fire && fs == is));
    mRelV = fire; mRelS = fs; mRelT = to;
    mRelM = '0;
    if (fire) begin
      mRelM = mHeld[fs];
      if (arriveValid && as == fs) mRelM = mRelM | nb;
    end
    for (int s = 0; s < NS; s++) begin
      if (fire && fs == s) begin
        mArmed[s] = 0; mRem[s] = 0; mTimer[s] = 0; mHeld[s] = '0;
      end else begin
        if (initValid && !bad && is == s) begin
          mArmed[s] = 1; mRem[s] = int'(initCount) + 1; mTimer[s] = int'(initLimit);
        end else if (mArmed[s]) begin
          if (hit && as == s) mRem[s] = mRem[s] - cnt;
          if (mTimer[s] > 1) mTimer[s] = mTimer[s] - 1;
        end
        if (arriveValid && as == s) mHeld[s] = mHeld[s] | nb;
      end
      if (initValid && bad && is == s) mErr[s] = 1'b1;
    end
  endtask

  task automatic compareModel();
    checks++;
    if (relValid !== mRelV || relMask !== mRelM || relTimeout !== mRelT ||
        errFlag !== mErr || (mRelV && int'(relSlot) != mRelS)) begin
      errors++;
      $display("FAIL %s model: act v=%0b s=%0d m=%h t=%0b e=%h exp v=%0b s=%0d m=%h t=%0b e=%h",
               curReq, relValid, relSlot, relMask, relTimeout, errFlag,
               mRelV, mRelS, mRelM, mRelT, mErr);
    end
  endtask

  task automatic step(input bit iv, input int is, input int ic, input int il,
                      input bit av, input int as, input logic [63:0] am);
    initValid = iv; initSlot = 2'(is); initCount = 8'(ic); initLimit = 16'(il);
    arriveValid = av; arriveSlot = 2'(as); arriveMask = am;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareModel();
    initValid = 0; arriveValid = 0; arriveMask = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic armSlot(input int s, input int c, input int l);
    step(1, s, c, l, 0, 0, '0);
  endtask

  task automatic arrive(input int s, input logic [63:0] m);
    step(0, 0, 0, 0, 1, s, m);
  endtask

  task automatic expectRel(input string req, input bit v, input int s,
                           input logic [63:0] m, input bit t);
    checks++;
    if (relValid !== v || relMask !== m || relTimeout !== t || (v && int'(relSlot) != s)) begin
      errors++;
      $display("FAIL %s release: act v=%0b s=%0d m=%h t=%0b exp v=%0b s=%0d m=%h t=%0b",
               req, relValid, relSlot, relMask, relTimeout, v, s, m, t);
    end
  endtask

  task automatic expectErr(input string req, input logic [3:0] e);
    checks++;
    if (errFlag !== e) begin
      errors++;
      $display("FAIL %s errFlag: act %h exp %h", req, errFlag, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    expectRel("R1", 0, 0, '0, 0);
    expectErr("R1", 4'h0);

    // R2: count 1 means two participants
    curReq = "R2";
    armSlot(0, 1, 0);
    arrive(0, 64'h8);
    expectRel("R2", 0, 0, '0, 0);
    arrive(0, 64'h80);
    expectRel("R2", 1, 0, 64'h88, 0);
    idle(1);
    expectRel("R3", 0, 0, '0, 0);

    // R8: multi-tag arrivals and duplicates
    curReq = "R8";
    armSlot(1, 4, 0);
    arrive(1, 64'h7);
    arrive(1, 64'h4);
    expectRel("R8", 0, 0, '0, 0);
    arrive(1, 64'h8000_0000_0000_0400);
    expectRel("R8", 1, 1, 64'h8000_0000_0000_0407, 0);

    // R3: full 64-wave barrier in one request
    curReq = "R3";
    armSlot(2, 63, 0);
    arrive(2, '1);
    expectRel("R3", 1, 2, '1, 0);

    // R4: two slots interleaved
    curReq = "R4";
    armSlot(0, 1, 0);
    armSlot(3, 1, 0);
    arrive(0, 64'h2);
    arrive(3, 64'h4);
    expectRel("R4", 0, 0, '0, 0);
    arrive(0, 64'h10);
    expectRel("R4", 1, 0, 64'h12, 0);

    // R5/R6: slot 1 is disarmed after its release; arrival hangs
    curReq = "R6";
    arrive(1, 64'h20);
    idle(20);
    expectRel("R5", 0, 0, '0, 0);
    curReq = "R7";
    armSlot(1, 0, 0);
    expectErr("R7", 4'h2);
    idle(5);
    expectRel("R6", 0, 0, '0, 0);

    // R7: arm refused on slot 3 which holds tag 2, then completes
    armSlot(3, 0, 0);
    expectErr("R7", 4'hA);
    arrive(3, 64'h200);
    expectRel("R7", 1, 3, 64'h204, 0);

    // R7: arm colliding with a same-cycle arrival
    armSlot(0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 64'h800);
    expectRel("R7", 1, 0, 64'h800, 0);
    expectErr("R7", 4'hB);

    // R9: watchdog, limit 5, armed at E0, fires at E5
    curReq = "R9";
    armSlot(2, 3, 5);
    arrive(2, 64'h100);
    idle(3);
    expectRel("R9", 0, 0, '0, 0);
    idle(1);
    expectRel("R9", 1, 2, 64'h100, 1);

    // R10: completion first, then expired slots lowest first
    curReq = "R10";
    armSlot(3, 0, 0);
    armSlot(2, 1, 3);
    armSlot(0, 0, 2);
    idle(1);
    arrive(3, 64'h10_0000);
    expectRel("R10", 1, 3, 64'h10_0000, 0);
    idle(1);
    expectRel("R10", 1, 0, '0, 1);
    idle(1);
    expectRel("R10", 1, 2, '0, 1);
    idle(2);
    expectRel("R10", 0, 0, '0, 0);
    expectErr("R7", 4'hB);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule